// File: doc/BRIEF.md
# Frame-Synchronous Line-Card Control Register Bank

This block is the byte-addressed control store for one channel of a telephony line card. A host-side serial engine (outside this block) turns its frames into single-cycle write strobes and combinational reads on a flat 8-bit address. The bank holds 128 balance-filter coefficient bytes, a channel mode bit, a scratch byte for link testing, a six-pin subscriber-line interface latch with per-pin direction, a pin readback word and a data-call status flag.

Everything that changes the signal path is tied to the PCM frame strobe. A write to the reset-control word is held in the register and is only acted on at the next frame strobe. At that point the bank either issues one-cycle state-reset pulses to the datapath or, when bit 0 is set, returns every control address to its default value. After a control reset, a busy flag locks out all writes for a fixed number of frames.

The reset-control sequencer has three named states. RC_IDLE moves to RC_ARMED on an accepted write to the reset-control word. RC_ARMED goes back to RC_IDLE at a frame strobe when bit 0 is clear (issuing pulses), or when the same cycle brings a new write it stays in RC_ARMED. It moves to RC_HOLD at a frame strobe when bit 0 is set (control reset). RC_HOLD moves back to RC_IDLE at the `BUSY_FRAMES`-th frame strobe that follows. A hardware reset forces RC_IDLE from any state.

Top module: `frame_ctrl_regbank`

## Requirements
- R1: Addresses 0..127 are read/write coefficient bytes. Each resets to 0x00, except address 3 and address 5, which reset to 0x80, and address 69, which resets to 0x88.
- R2: A write to address 128 stores its bits 3:0, which read back at once. Bits 7:4 always read 0. At the next frame strobe the stored bits return to 0.
- R3: When the word armed at address 128 has bit 0 clear, the cycle after the next frame strobe gives one-cycle pulses. Bit 3 drives `rst_datacall`, bit 2 drives `rst_echo` and bit 1 drives `rst_state`. No pulse appears before that frame strobe.
- R4: When the armed word has bit 0 set, the next frame strobe restores every control address to its default: coefficients, 129, 158, 159 and 162, plus the pending bits of 128. No state-reset pulse is issued, so 0x0F gives only a control reset.
- R5: `busy` rises with the control reset. It stays high across the following `BUSY_FRAMES` (default 3) frame strobes and falls after the last of them. All writes are ignored while `busy` is high.
- R6: Bit 0 of address 129 is `chan_active` (0 = standby, 1 = active), with default 0. Bits 7:1 read 0.
- R7: Address 158 bits 5:0 are the pin direction (1 = output), driven on `slic_oe`. Address 159 bits 5:0 are the pin output data, driven on `slic_out`. Both default to 0.
- R8: Address 160 reads the pin view captured at each frame strobe: a bit shows the data from 159 where its direction bit is 1, and `slic_in` elsewhere. It changes only on a frame strobe, and writes to it are ignored.
- R9: Address 162 is an 8-bit read/write scratch byte with default 0x00.
- R10: Address 167 bit 0 reads `datacall_in`, and writes to it are ignored. Every address not listed above reads 0.
- R11: A low `rst_n` restores every register to its default, discards any armed reset-control word and clears `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| frame_tick | input | 1 | One-cycle PCM frame strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| busy | output | 1 | Control-reset lockout, writes ignored while high |
| chan_active | output | 1 | Channel active (1) or standby (0) |
| slic_out | output | 6 | Pin output data |
| slic_oe | output | 6 | Pin output enables |
| slic_in | input | 6 | Sampled external pin levels |
| datacall_in | input | 1 | Data-call-in-progress status from the datapath |
| rst_datacall | output | 1 | One-cycle data-call state reset request |
| rst_echo | output | 1 | One-cycle echo-canceller coefficient clear request |
| rst_state | output | 1 | One-cycle general state reset request |

## Verification
The hardest case to reach is a reset-control word that sets bit 0 together with the state-reset bits. The discarded pulses and the wiped registers only show after a frame strobe, and the lockout lasts several frames. The stimulus first programs non-default values into the coefficient, mode, pin and scratch registers, then arms 0x0F and reads the word back before any frame. It then steps single frame strobes, checking that no pulse appears, that the defaults are back, and that a write during the lockout is lost. It finally checks that `busy` falls exactly after the third frame strobe.

// File: rtl/ctrl_bank_pkg.sv
package ctrl_bank_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int PIN_W  = 6;

    localparam logic [ADDR_W-1:0] A_RCTRL   = 8'd128;
    localparam logic [ADDR_W-1:0] A_MODE    = 8'd129;
    localparam logic [ADDR_W-1:0] A_PIN_DIR = 8'd158;
    localparam logic [ADDR_W-1:0] A_PIN_WR  = 8'd159;
    localparam logic [ADDR_W-1:0] A_PIN_RD  = 8'd160;
    localparam logic [ADDR_W-1:0] A_SCRATCH = 8'd162;
    localparam logic [ADDR_W-1:0] A_DCALL   = 8'd167;

    typedef enum logic [1:0] {
        RC_IDLE  = 2'd0,
        RC_ARMED = 2'd1,
        RC_HOLD  = 2'd2
    } rc_state_e;

    typedef struct packed {
        logic datacall;
        logic echo;
        logic state;
    } state_req_t;

    function automatic logic [DATA_W-1:0] coef_default(input int idx);
        if (idx == 3 || idx == 5) return 8'h80;
        if (idx == 69)            return 8'h88;
        return 8'h00;
    endfunction

endpackage

// File: rtl/coef_bank.sv
module coef_bank
    import ctrl_bank_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(coef_default(i));
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(coef_default(i));
        end else if (wr_en) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    AST_COEF_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (mem[$past(waddr)] == $past(wdata))); // R1

endmodule

// File: rtl/rctrl_seq.sv
module rctrl_seq
    import ctrl_bank_pkg::*;
#(
    parameter int BUSY_FRAMES = 3,
    localparam int CW = $clog2(BUSY_FRAMES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic       wr_rctrl,
    input  logic [3:0] wdata,
    output logic [3:0] pend,
    output logic       busy,
    output logic       ctrl_clr,
    output state_req_t req
);

    rc_state_e       st_q, st_d;
    logic [3:0]      pend_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    state_req_t      req_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RC_IDLE;
            pend  <= '0;
            cnt_q <= '0;
            req   <= '0;
        end else begin
            st_q  <= st_d;
            pend  <= pend_d;
            cnt_q <= cnt_d;
            req   <= req_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        pend_d   = pend;
        cnt_d    = cnt_q;
        req_d    = '0;
        ctrl_clr = 1'b0;
        unique case (st_q)
            RC_IDLE: begin
                if (wr_rctrl) begin
                    pend_d = wdata;
                    st_d   = RC_ARMED;
                end
            end
            RC_ARMED: begin
                if (frame_tick) begin
                    if (pend[0]) begin
                        ctrl_clr = 1'b1;
                        pend_d   = '0;
                        cnt_d    = '0;
                        st_d     = RC_HOLD;
                    end else begin
                        req_d.datacall = pend[3];
                        req_d.echo     = pend[2];
                        req_d.state    = pend[1];
                        if (wr_rctrl) begin
                            pend_d = wdata;
                            st_d   = RC_ARMED;
                        end else begin
                            pend_d = '0;
                            st_d   = RC_IDLE;
                        end
                    end
                end else if (wr_rctrl) begin
                    pend_d = wdata;
                end
            end
            RC_HOLD: begin
                if (frame_tick) begin
                    if (cnt_q == CW'(BUSY_FRAMES - 1)) begin
                        cnt_d = '0;
                        st_d  = RC_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = RC_IDLE;
        endcase
    end

    assign busy = (st_q == RC_HOLD);

    AST_PULSE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> $past(frame_tick)); // R3
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> !(|req)); // R3
    AST_CTRL_RESET_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (req == '0)); // R4
    AST_HOLD_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pend == '0)); // R4
    AST_BUSY_WAITS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_tick) |=> busy); // R5

endmodule

// File: rtl/pin_latch.sv
module pin_latch
    import ctrl_bank_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         frame_tick,
    input  logic         wr_dir,
    input  logic         wr_dat,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] view_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (clr) begin
            dir_q <= '0;
            dat_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            if (wr_dat) dat_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          view_q <= '0;
        else if (frame_tick) view_q <= (dir_q & dat_q) | (~dir_q & pin_in);
    end

    AST_VIEW_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(view_q)); // R8

endmodule

// File: rtl/frame_ctrl_regbank.sv
module frame_ctrl_regbank
    import ctrl_bank_pkg::*;
#(
    parameter int COEF_N      = 128,
    parameter int BUSY_FRAMES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_tick,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        busy,
    output logic        chan_active,
    output logic [5:0]  slic_out,
    output logic [5:0]  slic_oe,
    input  logic [5:0]  slic_in,
    input  logic        datacall_in,
    output logic        rst_datacall,
    output logic        rst_echo,
    output logic        rst_state
);

    localparam int CAW = $clog2(COEF_N);

    logic             wr_ok;
    logic             ctrl_clr;
    logic [3:0]       pend;
    state_req_t       req;
    logic [7:0]       coef_rd;
    logic [7:0]       scratch_q;
    logic             mode_q;
    logic [PIN_W-1:0] dir_q, dat_q, view_q;
    logic             coef_hit;

    assign wr_ok    = wr_en && !busy;
    assign coef_hit = (addr < 8'(COEF_N));

    coef_bank #(.DEPTH(COEF_N), .WIDTH(DATA_W)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_clr),
        .wr_en (wr_ok && coef_hit),
        .waddr (addr[CAW-1:0]),
        .wdata (wr_data),
        .raddr (addr[CAW-1:0]),
        .rdata (coef_rd)
    );

    rctrl_seq #(.BUSY_FRAMES(BUSY_FRAMES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .wr_rctrl   (wr_ok && addr == A_RCTRL),
        .wdata      (wr_data[3:0]),
        .pend       (pend),
        .busy       (busy),
        .ctrl_clr   (ctrl_clr),
        .req        (req)
    );

    pin_latch #(.W(PIN_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (ctrl_clr),
        .frame_tick (frame_tick),
        .wr_dir     (wr_ok && addr == A_PIN_DIR),
        .wr_dat     (wr_ok && addr == A_PIN_WR),
        .wdata      (wr_data[PIN_W-1:0]),
        .pin_in     (slic_in),
        .dir_q      (dir_q),
        .dat_q      (dat_q),
        .view_q     (view_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            scratch_q <= '0;
        end else if (ctrl_clr) begin
            mode_q    <= 1'b0;
            scratch_q <= '0;
        end else if (wr_ok) begin
            if (addr == A_MODE)    mode_q    <= wr_data[0];
            if (addr == A_SCRATCH) scratch_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (coef_hit) begin
            rd_data = coef_rd;
        end else begin
            case (addr)
                A_RCTRL:   rd_data = {4'b0, pend};
                A_MODE:    rd_data = {7'b0, mode_q};
                A_PIN_DIR: rd_data = {2'b0, dir_q};
                A_PIN_WR:  rd_data = {2'b0, dat_q};
                A_PIN_RD:  rd_data = {2'b0, view_q};
                A_SCRATCH: rd_data = scratch_q;
                A_DCALL:   rd_data = {7'b0, datacall_in};
                default:   rd_data = '0;
            endcase
        end
    end

    assign chan_active  = mode_q;
    assign slic_out     = dat_q;
    assign slic_oe      = dir_q;
    assign rst_datacall = req.datacall;
    assign rst_echo     = req.echo;
    assign rst_state    = req.state;

    AST_BUSY_LOCKS_SCRATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(scratch_q)); // R5
    AST_BUSY_LOCKS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(chan_active)); // R5
    AST_CLR_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !chan_active); // R4

endmodule

// File: tb/test_frame_ctrl_regbank.sv
module test_frame_ctrl_regbank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       busy, chan_active;
    logic [5:0] slic_out, slic_oe;
    logic [5:0] slic_in = '0;
    logic       datacall_in = 1'b0;
    logic       rst_datacall, rst_echo, rst_state;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    frame_ctrl_regbank i_frame_ctrl_regbank (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .busy(busy),
        .chan_active(chan_active), .slic_out(slic_out), .slic_oe(slic_oe),
        .slic_in(slic_in), .datacall_in(datacall_in),
        .rst_datacall(rst_datacall), .rst_echo(rst_echo), .rst_state(rst_state)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    function automatic logic [2:0] pulses();
        return {rst_datacall, rst_echo, rst_state};
    endfunction

    task automatic t_reset_state();
        logic [7:0] d;
        chk("R5 busy after reset", busy, 0);
        chk("R6 standby default", chan_active, 0);
        chk("R7 oe default", slic_oe, 0);
        chk("R3 no pulses at reset", pulses(), 0);
        rd(8'd0, d);   chk("R1 coef0 default", d, 8'h00);
        rd(8'd3, d);   chk("R1 coef3 default", d, 8'h80);
        rd(8'd5, d);   chk("R1 coef5 default", d, 8'h80);
        rd(8'd69, d);  chk("R1 coef69 default", d, 8'h88);
        rd(8'd127, d); chk("R1 coef127 default", d, 8'h00);
        rd(8'd162, d); chk("R9 scratch default", d, 8'h00);
    endtask

    task automatic t_plain_regs();
        logic [7:0] d;
        wr(8'd70, 8'hA5); rd(8'd70, d); chk("R1 coef70 write", d, 8'hA5);
        wr(8'd3, 8'h12);  rd(8'd3, d);  chk("R1 coef3 write", d, 8'h12);
        wr(8'd162, 8'h5A); rd(8'd162, d); chk("R9 scratch write", d, 8'h5A);
        wr(8'd129, 8'hFF); rd(8'd129, d); chk("R6 mode readback", d, 8'h01);
        chk("R6 active", chan_active, 1);
        datacall_in = 1'b1;
        wr(8'd167, 8'h00); rd(8'd167, d); chk("R10 datacall flag", d, 8'h01);
        datacall_in = 1'b0;
        rd(8'd167, d); chk("R10 datacall low", d, 8'h00);
        rd(8'd200, d); chk("R10 unmapped", d, 8'h00);
    endtask

    task automatic t_pins();
        logic [7:0] d;
        wr(8'd158, 8'h0F);
        wr(8'd159, 8'h35);
        chk("R7 oe", slic_oe, 6'h0F);
        chk("R7 out", slic_out, 6'h35);
        slic_in = 6'h2A;
        rd(8'd160, d); chk("R8 view before frame", d, 8'h00);
        frame();
        rd(8'd160, d); chk("R8 view after frame", d, 8'h25);
        wr(8'd160, 8'h3F);
        slic_in = 6'h10;
        rd(8'd160, d); chk("R8 write ignored, no refresh", d, 8'h25);
        frame();
        rd(8'd160, d); chk("R8 refreshed", d, 8'h15);
    endtask

    task automatic t_state_pulses();
        logic [7:0] d;
        wr(8'd128, 8'hFE);
        rd(8'd128, d); chk("R2 armed readback", d, 8'h0E);
        chk("R3 no pulse before frame", pulses(), 0);
        frame();
        chk("R3 all three pulses", pulses(), 3'b111);
        @(negedge clk);
        chk("R3 pulse one cycle", pulses(), 0);
        rd(8'd128, d); chk("R2 cleared at frame", d, 8'h00);
        wr(8'd128, 8'h04);
        frame();
        chk("R3 echo only", pulses(), 3'b010);
        wr(8'd128, 8'h08);
        frame();
        chk("R3 datacall only", pulses(), 3'b100);
        frame();
        chk("R3 no pulse on idle frame", pulses(), 0);
    endtask

    task automatic t_ctrl_reset();
        logic [7:0] d;
        wr(8'd3, 8'h33);
        wr(8'd162, 8'h66);
        wr(8'd129, 8'h01);
        wr(8'd128, 8'h0F);
        rd(8'd128, d); chk("R2 0x0F readback", d, 8'h0F);
        rd(8'd3, d); chk("R4 deferred until frame", d, 8'h33);
        frame();
        chk("R4 state pulses discarded", pulses(), 0);
        chk("R5 busy raised", busy, 1);
        rd(8'd3, d);   chk("R4 coef3 restored", d, 8'h80);
        rd(8'd70, d);  chk("R4 coef70 restored", d, 8'h00);
        rd(8'd162, d); chk("R4 scratch restored", d, 8'h00);
        rd(8'd128, d); chk("R4 rctrl cleared", d, 8'h00);
        chk("R4 standby", chan_active, 0);
        chk("R4 oe cleared", slic_oe, 0);
        chk("R4 out cleared", slic_out, 0);
        wr(8'd162, 8'h77);
        rd(8'd162, d); chk("R5 write during busy lost", d, 8'h00);
        frame(); chk("R5 busy after frame 1", busy, 1);
        frame(); chk("R5 busy after frame 2", busy, 1);
        frame(); chk("R5 busy after frame 3", busy, 0);
        wr(8'd162, 8'h77);
        rd(8'd162, d); chk("R5 write after busy", d, 8'h77);
    endtask

    task automatic t_hw_reset();
        logic [7:0] d;
        wr(8'd69, 8'h01);
        wr(8'd128, 8'h02);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'd128, d); chk("R11 pending dropped", d, 8'h00);
        rd(8'd69, d);  chk("R11 coef69 default", d, 8'h88);
        rd(8'd162, d); chk("R11 scratch default", d, 8'h00);
        frame();
        chk("R11 no pulse after reset", pulses(), 0);
        chk("R11 busy clear", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_plain_regs();
        t_pins();
        t_state_pulses();
        t_ctrl_reset();
        t_hw_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule